// File: doc/BRIEF.md
# Streaming Buffer with Replay

A single-clock first-in-first-out buffer for word streams. Storage is a circular register array with a read pointer and a write pointer that wrap at the end of the array. Writes go to the tail. Reads take from the head. The output runs in look-ahead mode: the head word and its packet-end bit are always on `rd_data`/`rd_last` while `rd_valid` is high. A read only moves the head forward.

Two early-warning flags compare the fill level with thresholds that can be changed at runtime. A `mark` pulse saves the position of the current head word. A later `rtx` pulse rewinds the head to that saved position and resets the fill level to match, so a packet can be replayed after an error. While a mark is saved, words that were read after it still occupy storage. They count toward `full` and cannot be overwritten until a new mark is taken or the buffer is reset.

Top module: `sfifo_rtx`

## Requirements
- R1: When `rst` is high at a clock edge, the buffer is empty afterwards: `level`=0, `rd_valid`=0, `full`=0, `overflow`=0, `underflow`=0, and no mark is saved.
- R2: Words leave in the order they were written. While `rd_valid` is 1, the oldest unread word is on `rd_data` before any read is issued. An accepted read removes it, and `level` drops by one.
- R3: The pointers wrap around the array. Order is kept when the total number of words written exceeds DEPTH, and `level` never exceeds DEPTH.
- R4: `full` is 1 when the stored span reaches DEPTH. A write while `full` is ignored: `level` and the head word do not change. `overflow` is high for exactly the one cycle after that write.
- R5: A read while `rd_valid` is 0 is ignored, and `underflow` is high for exactly the one cycle after it.
- R6: An accepted read and an accepted write in the same cycle leave `level` unchanged.
- R7: `almost_full` is 1 exactly when `level` >= `af_level`. `almost_empty` is 1 exactly when `level` <= `ae_level`.
- R8: The `wr_last` bit is stored with its word and comes out on `rd_last` together with that word.
- R9: `mark` saves the head position as it stands before any read in the same cycle. A later `rtx` sets the head back to that word and sets `level` to the number of words from it to the tail, including a word written in the same cycle.
- R10: While a mark is saved, words read after it stay stored. The stored span counts from the mark to the tail, so `full` can be 1 while `level` < DEPTH.
- R11: `rtx` with no mark saved has no effect. A read in the same cycle as an effective `rtx` is ignored and raises no `underflow`.
- R12: A new `mark` releases the protected words behind the old mark, and `full` is then decided by `level` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to append |
| wr_last | input | 1 | Packet-end bit for the word |
| full | output | 1 | No room for another write |
| rd_en | input | 1 | Read (advance head) request |
| rd_data | output | DATA_W | Head word (look-ahead) |
| rd_last | output | 1 | Packet-end bit of the head word |
| rd_valid | output | 1 | Head word present |
| mark | input | 1 | Save current head position |
| rtx | input | 1 | Rewind head to saved position |
| af_level | input | $clog2(DEPTH+1) | Almost-full threshold |
| ae_level | input | $clog2(DEPTH+1) | Almost-empty threshold |
| almost_full | output | 1 | level >= af_level |
| almost_empty | output | 1 | level <= ae_level |
| level | output | $clog2(DEPTH+1) | Unread words |
| overflow | output | 1 | Pulse after a dropped write |
| underflow | output | 1 | Pulse after a dropped read |

## Verification
A wrong fill count is visible on `level` and on the threshold flags in the cycle after the faulty update. A wrong read pointer shows up as the wrong look-ahead word in the same cycle. A lost or stale mark does not show until the later `rtx` or the next write near capacity. At that point `level`, `full` and the replayed head word all disagree with the expected values. The directed tests therefore check each rewind and each protected fill at the first cycle these effects can appear.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   // one cycle of requests presented to the pointer logic
   typedef struct packed {
      logic wr;
      logic rd;
      logic mark;
      logic rtx;
   } sfifo_op_t;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int EW    = DATA_W + 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [EW-1:0] wentry,
   input  logic [AW-1:0] raddr,
   output logic [EW-1:0] rentry
);
   logic [EW-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(i))) cells[i] <= wentry;
      end
   end

   assign rentry = cells[raddr];
endmodule

// File: rtl/sfifo_ptr.sv
module sfifo_ptr
   import sfifo_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  sfifo_op_t     op,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] level,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic          wr_take,
   output logic          overflow,
   output logic          underflow
);
   logic [AW-1:0] mark_ptr;
   logic          mark_ok;
   logic [CW-1:0] count;
   logic [CW-1:0] span;
   logic [AW-1:0] wr_nxt, rd_nxt;
   logic          rd_take, rewind, save;
   logic [CW-1:0] wa, ra;

   // pointer increment: natural wrap for power-of-two depth, compare otherwise
   if (is_pow2(DEPTH)) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
   end

   assign full    = (span == CW'(DEPTH));
   assign empty   = (count == '0);
   assign rewind  = op.rtx && mark_ok;
   assign save    = op.mark && !rewind;
   assign wr_take = op.wr && !full;
   assign rd_take = op.rd && !empty && !rewind;
   assign wa      = CW'(wr_take);
   assign ra      = CW'(rd_take);
   assign level   = count;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         mark_ptr  <= '0;
         mark_ok   <= 1'b0;
         count     <= '0;
         span      <= '0;
         overflow  <= 1'b0;
         underflow <= 1'b0;
      end else begin
         overflow  <= op.wr && full;
         underflow <= op.rd && empty && !rewind;
         if (wr_take) wr_ptr <= wr_nxt;
         if (rewind) begin
            rd_ptr <= mark_ptr;
            count  <= span + wa;
            span   <= span + wa;
         end else begin
            if (rd_take) rd_ptr <= rd_nxt;
            count <= count + wa - ra;
            if (save) begin
               mark_ptr <= rd_ptr;
               mark_ok  <= 1'b1;
               span     <= count + wa;
            end else if (mark_ok) begin
               span <= span + wa;
            end else begin
               span <= count + wa - ra;
            end
         end
      end
   end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] af_level,
   input  logic [CW-1:0] ae_level,
   output logic          almost_full,
   output logic          almost_empty
);
   assign almost_full  = (level >= af_level);
   assign almost_empty = (level <= ae_level);
endmodule

// File: rtl/sfifo_rtx.sv
module sfifo_rtx
   import sfifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   output logic              full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              rd_valid,
   input  logic              mark,
   input  logic              rtx,
   input  logic [CW-1:0]     af_level,
   input  logic [CW-1:0]     ae_level,
   output logic              almost_full,
   output logic              almost_empty,
   output logic [CW-1:0]     level,
   output logic              overflow,
   output logic              underflow
);
   if (DEPTH < 2)  begin : g_bad_depth $error("sfifo_rtx: DEPTH must be at least 2"); end
   if (DATA_W < 1) begin : g_bad_width $error("sfifo_rtx: DATA_W must be at least 1"); end

   sfifo_op_t     op;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr_take, empty;
   logic [DATA_W:0] head;

   assign op = '{wr: wr_en, rd: rd_en, mark: mark, rtx: rtx};

   sfifo_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk(clk), .rst(rst), .op(op), .full(full), .empty(empty),
      .level(level), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_take(wr_take),
      .overflow(overflow), .underflow(underflow)
   );

   sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we(wr_take), .waddr(wr_ptr), .wentry({wr_last, wr_data}),
      .raddr(rd_ptr), .rentry(head)
   );

   sfifo_flags #(.DEPTH(DEPTH)) u_flags (
      .level(level), .af_level(af_level), .ae_level(ae_level),
      .almost_full(almost_full), .almost_empty(almost_empty)
   );

   assign rd_valid = !empty;
   assign rd_data  = head[DATA_W-1:0];
   assign rd_last  = head[DATA_W];
endmodule

// File: rtl/sfifo_rtx_chk.sv
module sfifo_rtx_chk #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic          rd_en,
   input logic          mark,
   input logic          rtx,
   input logic          full,
   input logic          rd_valid,
   input logic [CW-1:0] level,
   input logic [CW-1:0] af_level,
   input logic [CW-1:0] ae_level,
   input logic          almost_full,
   input logic          almost_empty,
   input logic          overflow,
   input logic          underflow
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (level == '0 && !overflow && !underflow));
   // R3
   level_bound_chk: assert property (@(posedge clk) disable iff (rst) level <= CW'(DEPTH));
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst) (wr_en && full) |=> overflow);
   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && full && !rd_en && !rtx) |=> $stable(level));
   // R5
   no_underflow_chk: assert property (@(posedge clk) disable iff (rst) (rd_en && !rd_valid && !rtx) |=> underflow);
   // R6
   balanced_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !full && rd_en && rd_valid && !rtx) |=> $stable(level));
   // R2
   read_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_valid && !wr_en && !rtx) |=> (level == $past(level) - CW'(1)));
   // R7
   thresh_chk: assert property (@(posedge clk) disable iff (rst)
      (almost_full == (level >= af_level)) && (almost_empty == (level <= ae_level)));
endmodule

bind sfifo_rtx sfifo_rtx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .mark(mark), .rtx(rtx),
   .full(full), .rd_valid(rd_valid), .level(level), .af_level(af_level),
   .ae_level(ae_level), .almost_full(almost_full), .almost_empty(almost_empty),
   .overflow(overflow), .underflow(underflow)
);

// File: tb/tb_sfifo_rtx.sv
module tb_sfifo_rtx;
   localparam int DW = 8;
   localparam int DEPTH = 16;
   localparam int CW = $clog2(DEPTH + 1);

   logic clk = 0, rst = 1;
   logic wr_en = 0, wr_last = 0, rd_en = 0, mark = 0, rtx = 0;
   logic [DW-1:0] wr_data = '0;
   logic [CW-1:0] af_level = CW'(12), ae_level = CW'(2);
   logic full, rd_last, rd_valid, almost_full, almost_empty, overflow, underflow;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] level;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   sfifo_rtx #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
      .full(full), .rd_en(rd_en), .rd_data(rd_data), .rd_last(rd_last),
      .rd_valid(rd_valid), .mark(mark), .rtx(rtx), .af_level(af_level),
      .ae_level(ae_level), .almost_full(almost_full), .almost_empty(almost_empty),
      .level(level), .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   // drive one cycle at the falling edge, sample just after the rising edge
   task automatic step(input bit w, input int d, input bit l, input bit r, input bit m, input bit x);
      @(negedge clk);
      wr_en = w; wr_data = DW'(d); wr_last = l; rd_en = r; mark = m; rtx = x;
      @(posedge clk); #1;
      @(negedge clk);
      wr_en = 0; rd_en = 0; mark = 0; rtx = 0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1;
      @(posedge clk); #1;
      @(negedge clk); rst = 0;
   endtask

   task automatic t_reset();
      do_reset();
      chk_eq("R1 level", int'(level), 0);
      chk_eq("R1 rd_valid", int'(rd_valid), 0);
      chk_eq("R1 full", int'(full), 0);
      chk_eq("R1 overflow", int'(overflow), 0);
      chk_eq("R1 almost_empty", int'(almost_empty), 1);
   endtask

   task automatic t_order();
      do_reset();
      for (int i = 0; i < 5; i++) step(1, 8'h40 + i, i == 2, 0, 0, 0);
      chk_eq("R2 look-ahead head", int'(rd_data), 8'h40);
      chk_eq("R2 level", int'(level), 5);
      for (int i = 0; i < 5; i++) begin
         chk_eq("R2 order", int'(rd_data), 8'h40 + i);
         chk_eq("R8 last bit", int'(rd_last), (i == 2) ? 1 : 0);
         step(0, 0, 0, 1, 0, 0);
      end
      chk_eq("R2 drained", int'(rd_valid), 0);
   endtask

   task automatic t_full();
      do_reset();
      for (int i = 0; i < DEPTH; i++) step(1, 8'h80 + i, 0, 0, 0, 0);
      chk_eq("R4 full", int'(full), 1);
      chk_eq("R4 level", int'(level), DEPTH);
      step(1, 8'hEE, 0, 0, 0, 0);
      chk_eq("R4 overflow pulse", int'(overflow), 1);
      chk_eq("R4 level held", int'(level), DEPTH);
      step(0, 0, 0, 0, 0, 0);
      chk_eq("R4 overflow one cycle", int'(overflow), 0);
      chk_eq("R4 head kept", int'(rd_data), 8'h80);
   endtask

   task automatic t_wrap();
      do_reset();
      for (int i = 0; i < 12; i++) step(1, i, 0, 0, 0, 0);
      for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 12; i++) step(1, 8'hA0 + i, 0, 0, 0, 0);
      chk_eq("R3 level after wrap", int'(level), 12);
      for (int i = 0; i < 12; i++) begin
         chk_eq("R3 order across wrap", int'(rd_data), 8'hA0 + i);
         step(0, 0, 0, 1, 0, 0);
      end
   endtask

   task automatic t_empty();
      do_reset();
      step(0, 0, 0, 1, 0, 0);
      chk_eq("R5 underflow pulse", int'(underflow), 1);
      chk_eq("R5 level", int'(level), 0);
      step(0, 0, 0, 0, 0, 0);
      chk_eq("R5 underflow one cycle", int'(underflow), 0);
   endtask

   task automatic t_simul();
      do_reset();
      for (int i = 0; i < 3; i++) step(1, 8'h10 + i, 0, 0, 0, 0);
      step(1, 8'h13, 0, 1, 0, 0);
      chk_eq("R6 level steady", int'(level), 3);
      chk_eq("R6 head advanced", int'(rd_data), 8'h11);
   endtask

   task automatic t_flags();
      do_reset();
      af_level = CW'(4); ae_level = CW'(1);
      step(1, 1, 0, 0, 0, 0);
      chk_eq("R7 ae at threshold", int'(almost_empty), 1);
      step(1, 2, 0, 0, 0, 0);
      chk_eq("R7 ae above", int'(almost_empty), 0);
      step(1, 3, 0, 0, 0, 0);
      chk_eq("R7 af below", int'(almost_full), 0);
      step(1, 4, 0, 0, 0, 0);
      chk_eq("R7 af at threshold", int'(almost_full), 1);
      af_level = CW'(12); ae_level = CW'(2);
   endtask

   task automatic t_rtx();
      do_reset();
      for (int i = 0; i < 6; i++) step(1, 8'h20 + i, i == 5, 0, 0, 0);
      step(0, 0, 0, 1, 1, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0);
      chk_eq("R9 level before rewind", int'(level), 2);
      step(0, 0, 0, 0, 0, 1);
      chk_eq("R9 level after rewind", int'(level), 6);
      chk_eq("R9 replay head", int'(rd_data), 8'h20);
      step(0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 1, 0, 1);
      chk_eq("R11 read ignored on rewind", int'(level), 6);
      chk_eq("R11 head on rewind", int'(rd_data), 8'h20);
      chk_eq("R11 no underflow", int'(underflow), 0);
      step(1, 8'h30, 0, 0, 0, 1);
      chk_eq("R9 rewind with write", int'(level), 7);
   endtask

   task automatic t_protect();
      do_reset();
      step(0, 0, 0, 0, 1, 0);
      for (int i = 0; i < DEPTH; i++) step(1, 8'h50 + i, 0, 0, 0, 0);
      for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, 0);
      chk_eq("R10 level", int'(level), 6);
      chk_eq("R10 full while protected", int'(full), 1);
      step(1, 8'hFF, 0, 0, 0, 0);
      chk_eq("R10 write refused", int'(overflow), 1);
      step(0, 0, 0, 0, 1, 0);
      chk_eq("R12 released", int'(full), 0);
      step(1, 8'h77, 0, 0, 0, 0);
      chk_eq("R12 write accepted", int'(level), 7);
   endtask

   task automatic t_nomark();
      do_reset();
      for (int i = 0; i < 3; i++) step(1, 8'h60 + i, 0, 0, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 1);
      chk_eq("R11 no mark level", int'(level), 1);
      chk_eq("R11 no mark head", int'(rd_data), 8'h62);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_order();
      t_full();
      t_wrap();
      t_empty();
      t_simul();
      t_flags();
      t_rtx();
      t_protect();
      t_nomark();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule